// File: doc/BRIEF.md
# Channel Read-Latency Levelling Calibrator

This block runs once after power-up or any reset, before normal traffic may use the memory channel. The channel is routed as a serpentine, so a read command takes longer to reach the far devices and their data takes longer to come back. A far device can therefore see about twice the one-way flight-time spread, up to roughly 10 ns more round-trip latency than a near one. The calibrator sends calibration reads to every device in turn. For each read it counts controller cycles until data comes back, and it keeps the worst result per device.

Once all devices are measured, the slowest device sets the target. Every device is then programmed with an extra column-access delay equal to the target minus its own latency. After that, all devices return data with the same total latency. Firmware only pulses `start` and waits for `done`. `error` reports a read that never answered or a device whose gap exceeds the delay field.

The controller is a five-state machine:
- **IDLE**: after reset. Goes to ISSUE on `start`.
- **ISSUE**: drives one command cycle. Always goes to WAIT.
- **WAIT**: counts return cycles.
  - Goes back to ISSUE when data arrives or the timeout expires.
  - Goes to WRITE after the last read of the last device.
- **WRITE**: emits one delay write per cycle. Goes to DONE after the last device.
- **DONE**: holds the result. Goes to ISSUE on a new `start`.

Top module: `rdlat_leveler`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done`, `error`, `rd_cmd` and `wr_en` are low.
- R2: A `start` seen in IDLE or DONE makes `rd_cmd` high in the next cycle with `rd_dev` = 0. Each command lasts exactly one cycle. Devices are visited in ascending index, each receiving READS commands. The next command follows in the cycle after the read ends.
- R3: A read's latency is the number of cycles from its command cycle to the cycle in which `data_valid` is high; 1 means the cycle right after the command. A device's latency is the largest over its reads. `data_valid` outside the waiting interval has no effect.
- R4: If no data returns within TIMEOUT cycles after a command, the read ends after exactly TIMEOUT waiting cycles, contributes latency 0, and sets `error`. Data arriving in the TIMEOUT-th cycle still counts as a normal return.
- R5: After the final read, `wr_en` is high for N_DEV consecutive cycles, with `wr_dev` going 0,1,...,N_DEV-1. `wr_dly` equals the largest device latency minus that device's latency.
- R6: A delay above DLY_MAX is written as DLY_MAX, and `error` is set.
- R7: `error` is cleared when a run is accepted and, once set in a run, stays high through DONE.
- R8: `done` is high from the cycle after the last write until the next accepted `start`. No command or write is issued while `done` is high. A `start` during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (pulse) |
| data_valid | input | 1 | First beat of returned calibration data |
| rd_cmd | output | 1 | One-cycle calibration read command |
| rd_dev | output | $clog2(N_DEV) | Device addressed by `rd_cmd` |
| wr_en | output | 1 | Delay-register write strobe |
| wr_dev | output | $clog2(N_DEV) | Device whose delay is written |
| wr_dly | output | DLY_W | Extra column-access delay value |
| done | output | 1 | Calibration complete |
| error | output | 1 | Timeout or delay saturation in this run |

## Verification
The properties assume `start` is a pulse, and that the channel answers each command with at most one single-cycle `data_valid`, never before the command has ended. The bench channel model schedules exactly one return per command from a configured latency table, or none when emulating a dead device. Stray `data_valid` is injected only while the machine sits in IDLE. The busy-time `start` pulse is placed in a run that raises no timeout, so an early error cannot be confused with a missed clear.

// File: rtl/rdlev_pkg.sv
package rdlev_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } lvl_state_e;
endpackage

// File: rtl/lvl_timer.sv
// Return-latency counter: loads 1 on clear, counts while run is high.
module lvl_timer #(
    parameter int LAT_W   = 6,
    parameter int TIMEOUT = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [LAT_W-1:0] count,
    output logic             expired
);
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= LAT_W'(1);
        else if (run)    count <= count + 1'b1;
    end

    assign expired = (count == LAT_W'(TIMEOUT));
endmodule

// File: rtl/lvl_delay.sv
// Per-device delay: target minus own latency, clamped to the field maximum.
module lvl_delay #(
    parameter int LAT_W   = 6,
    parameter int DLY_W   = 4,
    parameter int DLY_MAX = 15
) (
    input  logic [LAT_W-1:0] target,
    input  logic [LAT_W-1:0] dev_lat,
    output logic [DLY_W-1:0] dly,
    output logic             over
);
    logic [LAT_W-1:0] gap;

    always_comb begin
        gap  = target - dev_lat;
        over = (gap > LAT_W'(DLY_MAX));
        dly  = over ? DLY_W'(DLY_MAX) : gap[DLY_W-1:0];
    end
endmodule

// File: rtl/rdlat_leveler.sv
module rdlat_leveler #(
    parameter int N_DEV   = 32,
    parameter int READS   = 4,
    parameter int LAT_W   = 6,
    parameter int TIMEOUT = 63,
    parameter int DLY_W   = 4,
    parameter int DLY_MAX = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       data_valid,
    output logic                       rd_cmd,
    output logic [$clog2(N_DEV)-1:0]   rd_dev,
    output logic                       wr_en,
    output logic [$clog2(N_DEV)-1:0]   wr_dev,
    output logic [DLY_W-1:0]           wr_dly,
    output logic                       done,
    output logic                       error
);
    import rdlev_pkg::*;

    localparam int DEV_W = $clog2(N_DEV);
    localparam int RD_W  = (READS > 1) ? $clog2(READS) : 1;

    lvl_state_e       state, state_nx;
    logic [DEV_W-1:0] dev_idx;
    logic [RD_W-1:0]  rd_idx;
    logic [LAT_W-1:0] lat_mem [N_DEV];
    logic [LAT_W-1:0] target;
    logic             err_q;

    logic [LAT_W-1:0] cnt;
    logic             expired;
    logic [LAT_W-1:0] sample;
    logic [DLY_W-1:0] calc_dly;
    logic             calc_over;
    logic             last_dev, last_rd, accept, read_end;

    assign last_dev = (dev_idx == DEV_W'(N_DEV - 1));
    assign last_rd  = (rd_idx == RD_W'(READS - 1));
    assign accept   = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign read_end = (state == ST_WAIT) && (data_valid || expired);
    assign sample   = data_valid ? cnt : '0;

    lvl_timer #(.LAT_W(LAT_W), .TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_ISSUE),
        .run     (state == ST_WAIT),
        .count   (cnt),
        .expired (expired)
    );

    lvl_delay #(.LAT_W(LAT_W), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_delay (
        .target  (target),
        .dev_lat (lat_mem[dev_idx]),
        .dly     (calc_dly),
        .over    (calc_over)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (data_valid || expired)
                          state_nx = (last_rd && last_dev) ? ST_WRITE : ST_ISSUE;
            ST_WRITE: if (last_dev) state_nx = ST_DONE;
            ST_DONE:  if (start) state_nx = ST_ISSUE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // measurement and bookkeeping of indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_idx <= '0;
            rd_idx  <= '0;
            target  <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            dev_idx <= '0;
            rd_idx  <= '0;
            target  <= '0;
            err_q   <= 1'b0;
        end else if (read_end) begin
            if (!data_valid) err_q <= 1'b1;
            if (rd_idx == '0 || sample > lat_mem[dev_idx])
                lat_mem[dev_idx] <= sample;
            if (sample > target) target <= sample;
            if (last_rd) begin
                rd_idx  <= '0;
                dev_idx <= last_dev ? '0 : dev_idx + 1'b1;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end else if (state == ST_WRITE) begin
            if (calc_over) err_q <= 1'b1;
            dev_idx <= last_dev ? '0 : dev_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        rd_cmd = 1'b0;
        wr_en  = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_ISSUE: rd_cmd = 1'b1;
            ST_WRITE: wr_en  = 1'b1;
            ST_DONE:  done   = 1'b1;
            default:  ;
        endcase
        rd_dev = dev_idx;
        wr_dev = dev_idx;
        wr_dly = calc_dly;
        error  = err_q;
    end
endmodule

// File: rtl/rdlat_leveler_chk.sv
module rdlat_leveler_chk #(
    parameter int N_DEV   = 32,
    parameter int DLY_W   = 4,
    parameter int DLY_MAX = 15
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     rd_cmd,
    input logic [$clog2(N_DEV)-1:0] rd_dev,
    input logic                     wr_en,
    input logic [$clog2(N_DEV)-1:0] wr_dev,
    input logic [DLY_W-1:0]         wr_dly,
    input logic                     done,
    input logic                     error
);
    localparam int DEV_W = $clog2(N_DEV);

    a_r2_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> !rd_cmd);

    a_r5_wr_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_dev == DEV_W'($past(wr_dev) + 1'b1)));

    a_r6_dly_cap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_dly <= DLY_W'(DLY_MAX)));

    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_cmd && !wr_en));

    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && $past(start && done)) |-> (!error && rd_dev == '0));
endmodule

bind rdlat_leveler rdlat_leveler_chk #(
    .N_DEV   (N_DEV),
    .DLY_W   (DLY_W),
    .DLY_MAX (DLY_MAX)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .rd_cmd (rd_cmd),
    .rd_dev (rd_dev),
    .wr_en  (wr_en),
    .wr_dev (wr_dev),
    .wr_dly (wr_dly),
    .done   (done),
    .error  (error)
);

// File: tb/tb_rdlat_leveler.sv
module tb_rdlat_leveler;
    localparam int N       = 4;
    localparam int RD      = 2;
    localparam int TMO     = 40;
    localparam int DMAX    = 10;
    localparam int DW      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dv_ch = 1'b0;
    logic dv_stray = 1'b0;
    logic data_valid;
    logic rd_cmd, wr_en, done, error;
    logic [1:0] rd_dev, wr_dev;
    logic [DW-1:0] wr_dly;

    assign data_valid = dv_ch | dv_stray;
    always #4 clk = ~clk;

    rdlat_leveler #(.N_DEV(N), .READS(RD), .LAT_W(6), .TIMEOUT(TMO),
                    .DLY_W(DW), .DLY_MAX(DMAX)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .data_valid(data_valid),
        .rd_cmd(rd_cmd), .rd_dev(rd_dev), .wr_en(wr_en), .wr_dev(wr_dev),
        .wr_dly(wr_dly), .done(done), .error(error));

    int total = 0, bad = 0, cycles = 0;
    int base [N];
    int jit  [N];
    int rdcount [N];
    int countdown = 0;
    // expected per-cycle trace: kind 0 wait, 1 command, 2 write, 3 steady
    int qk[$];
    int qd[$];
    int qv[$];
    int exp_err = 0;
    int done_idle = 0;

    function automatic int read_lat(int d, int r);
        if (base[d] == 0) return 0;
        return base[d] + ((r == RD - 1) ? jit[d] : 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycles);
        end
    endtask

    // channel model and per-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "watchdog", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        dv_ch = 1'b0;
        if (countdown > 0) begin
            countdown--;
            if (countdown == 0) dv_ch = 1'b1;
        end
        if (rst_n) begin
            if (rd_cmd) begin
                countdown = read_lat(int'(rd_dev), rdcount[rd_dev]);
                rdcount[rd_dev]++;
            end
            if (qk.size() != 0) begin
                int k, d, v;
                k = qk.pop_front(); d = qd.pop_front(); v = qv.pop_front();
                case (k)
                    0: check(!rd_cmd && !wr_en && !done, "R3 wait cycle quiet",
                             {rd_cmd, wr_en, done}, 0);
                    1: begin
                        check(rd_cmd && !wr_en && rd_dev == d[1:0], "R2 command device",
                              rd_cmd ? int'(rd_dev) : -1, d);
                        if (d == 0) check(!error, "R7 error cleared", error, 0);
                    end
                    2: begin
                        check(wr_en && !rd_cmd && wr_dev == d[1:0], "R5 write device",
                              wr_en ? int'(wr_dev) : -1, d);
                        check(wr_dly == v[DW-1:0], "R5/R6 write delay", wr_dly, v);
                    end
                    default: check(!rd_cmd && !wr_en && done == v[0], "R8 steady before run",
                                   done, v);
                endcase
            end else begin
                check(!rd_cmd && !wr_en && done == done_idle[0], "R8 done level", done, done_idle);
                check(error == exp_err[0], "R4/R6/R7 error flag", error, exp_err);
            end
        end else begin
            check(!done && !error && !rd_cmd && !wr_en, "R1 reset outputs",
                  {done, error, rd_cmd, wr_en}, 0);
        end
    end

    task automatic do_run(input bit poke_busy);
        int dlat [N];
        int tgt, e, gap, l;
        tgt = 0; e = 0;
        qk.push_back(3); qd.push_back(0); qv.push_back(done_idle);
        for (int d = 0; d < N; d++) begin
            dlat[d] = 0;
            rdcount[d] = 0;
            for (int r = 0; r < RD; r++) begin
                l = read_lat(d, r);
                qk.push_back(1); qd.push_back(d); qv.push_back(0);
                if (l == 0) begin
                    e = 1;
                    l = TMO;
                    for (int c = 0; c < l; c++) begin qk.push_back(0); qd.push_back(0); qv.push_back(0); end
                end else begin
                    for (int c = 0; c < l; c++) begin qk.push_back(0); qd.push_back(0); qv.push_back(0); end
                    if (l > dlat[d]) dlat[d] = l;
                end
            end
            if (dlat[d] > tgt) tgt = dlat[d];
        end
        for (int d = 0; d < N; d++) begin
            gap = tgt - dlat[d];
            if (gap > DMAX) begin gap = DMAX; e = 1; end
            qk.push_back(2); qd.push_back(d); qv.push_back(gap);
        end
        exp_err = e;
        done_idle = 1;
        start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        if (poke_busy) begin
            // R8: start while busy must not disturb the trace
            repeat (5) @(posedge clk);
            #2 start = 1'b1;
            @(posedge clk); #2 start = 1'b0;
        end
        while (qk.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
    endtask

    initial begin
        for (int d = 0; d < N; d++) begin base[d] = 0; jit[d] = 0; rdcount[d] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        // R3: stray data_valid in IDLE has no effect
        dv_stray = 1'b1;
        repeat (3) @(posedge clk);
        #2 dv_stray = 1'b0;
        // Run A: spread within range, jitter on last read (R2, R3, R5), busy start (R8)
        base = '{5, 9, 7, 12}; jit = '{2, 0, 1, 0};
        do_run(1'b1);
        // Run B: all equal -> zero delays
        base = '{8, 8, 8, 8}; jit = '{0, 0, 0, 0};
        do_run(1'b0);
        // Run C: spread beyond field -> saturation and error (R6)
        base = '{3, 20, 15, 1}; jit = '{0, 0, 0, 0};
        do_run(1'b0);
        // Run D: restart clears error (R7), response right at timeout counts (R4)
        base = '{1, TMO, 35, 38}; jit = '{0, 0, 0, 0};
        do_run(1'b0);
        // Run E: device 2 silent -> timeout, zero latency, error (R4)
        base = '{6, 9, 0, 10}; jit = '{0, 0, 0, 0};
        do_run(1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule